// File: doc/BRIEF.md
# NCO Frequency and Phase Accumulator

This block is the frequency-control datapath of a numerically controlled oscillator. A 16-bit control bus, together with an active-low write strobe, an active-low select and a 3-bit address, fills staging registers for two 32-bit frequency words. One word is the center frequency and the other is the offset frequency. Each word is written as two 16-bit halves. A frequency register copies its staged word on the system clock, but only while its enable is active.

The adder sums the center and offset frequencies, and the phase accumulator adds that sum to itself on every enabled clock edge. The top 16 bits of the accumulator form the phase word, which goes to a sine/cosine lookup outside this block. Every control pin is active low and passes through one clock register before it acts. Two controls shape the datapath without changing any stored state. The inhibit control removes the offset term from the adder input. The initialize control removes the accumulator feedback, so the next enabled update loads only the frequency sum.

The phase output is a free-running sample stream. It has no valid/ready handshake and accepts no back-pressure: a consumer samples it on every clock and pauses it only through the accumulator enable. Control pins are plain levels.

Top module: `nco_phase_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, the frequency registers and the accumulator are cleared and every registered control is made inactive (high). As a result, `phase_out` is 0 after reset.
- R2: A staging register captures `cdata` on the rising edge of `wr_n`, and only if `cs_n` is low at that edge. A strobe edge while `cs_n` is high changes nothing.
- R3: The address map for `addr` is: 0 = center low half (bits 15:0), 1 = center high half (bits 31:16), 2 = offset low half, 3 = offset high half. Addresses 4 to 7 write nothing. A write to one half leaves the other half unchanged.
- R4: Each control pin (`cf_en_n`, `of_en_n`, `acc_en_n`, `inh_of_n`, `init_acc_n`) is captured by one clock register, and only the captured value acts. If a pin is first seen low at clock edge n, its action first appears at edge n+1.
- R5: The center and offset frequency registers copy their staged words only on edges where their registered enable is low. On all other edges they hold their value.
- R6: While the registered inhibit is low, the adder uses zero in place of the offset register. The offset register still loads when enabled, and its contents are kept, so the full sum returns when the inhibit is released.
- R7: While the registered initialize is low, the accumulator feedback is zero, so an enabled update loads just the frequency sum. The initialize control never clears the accumulator on its own: with the accumulator disabled, the phase holds.
- R8: On each edge where the registered accumulator enable is low, the accumulator adds (center + offset term) modulo 2^32. On other edges it holds.
- R9: `phase_out` equals bits 31:16 of the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, data taken on rising edge |
| cs_n | input | 1 | Select for strobe writes, active low |
| addr | input | 3 | Staging register address |
| cdata | input | 16 | Control data bus |
| cf_en_n | input | 1 | Center frequency load enable, active low |
| of_en_n | input | 1 | Offset frequency load enable, active low |
| acc_en_n | input | 1 | Accumulator enable, active low |
| inh_of_n | input | 1 | Offset inhibit, active low |
| init_acc_n | input | 1 | Accumulator feedback zeroing, active low |
| phase_out | output | 16 | Top 16 bits of the phase accumulator |

## Verification
Some properties are checked on every clock cycle. The frequency registers and the accumulator hold whenever their registered enable is high. Under inhibit, the adder output equals the center register. Each enabled update equals either the previous accumulator plus the previous sum, or the previous sum alone when initialize is active. Other behaviour is shown only by the bench scenarios, which look at `phase_out`. These cover the strobe and select qualification, the address decode with its ignored addresses, half-word independence, the one-cycle pipelining of the pins, the retained offset after inhibit, and wraparound over a sweep of frequency words.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned NCO_FW = 32;
  localparam int unsigned NCO_BW = 16;
  localparam int unsigned NCO_PW = 16;
  localparam int unsigned NCO_AW = 3;
  localparam int unsigned NCO_NCTL = 5;
  localparam int unsigned CTL_CF   = 0;
  localparam int unsigned CTL_OF   = 1;
  localparam int unsigned CTL_ACC  = 2;
  localparam int unsigned CTL_INH  = 3;
  localparam int unsigned CTL_INIT = 4;
endpackage

// File: rtl/nco_stage_regs.sv
module nco_stage_regs #(
  parameter int unsigned FW = 32,
  parameter int unsigned BW = 16,
  parameter int unsigned AW = 3
) (
  input  logic          wr_n,
  input  logic          cs_n,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] cdata,
  output logic [FW-1:0] cf_stage,
  output logic [FW-1:0] of_stage
);
  localparam int unsigned HALVES = FW / BW;
  localparam int unsigned NWORDS = 2;

  logic [FW-1:0] words [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    for (genvar h = 0; h < HALVES; h++) begin : g_half
      localparam logic [AW-1:0] MY_ADDR = AW'(w * HALVES + h);
      logic [BW-1:0] half_q;
      always_ff @(posedge wr_n) begin
        if (!cs_n && addr == MY_ADDR) half_q <= cdata;
      end
      assign words[w][h*BW +: BW] = half_q;
    end
  end

  assign cf_stage = words[0];
  assign of_stage = words[1];
endmodule

// File: rtl/nco_ctl_pipe.sv
module nco_ctl_pipe #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pins_n,
  output logic [N-1:0] ctl_q_n
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) ctl_q_n[i] <= 1'b1;
      else     ctl_q_n[i] <= pins_n[i];
    end
  end
endmodule

// File: rtl/nco_freq_path.sv
module nco_freq_path #(
  parameter int unsigned FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] cf_stage,
  input  logic [FW-1:0] of_stage,
  input  logic          cf_ld_n,
  input  logic          of_ld_n,
  input  logic          inh_n,
  output logic [FW-1:0] freq_sum
);
  logic [FW-1:0] cf_q, of_q, of_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      cf_q <= '0;
      of_q <= '0;
    end else begin
      if (!cf_ld_n) cf_q <= cf_stage;
      if (!of_ld_n) of_q <= of_stage;
    end
  end

  assign of_term  = inh_n ? of_q : '0;
  assign freq_sum = cf_q + of_term;

  // R5
  cf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cf_ld_n |=> $stable(cf_q));
  // R5
  of_hold_chk: assert property (@(posedge clk) disable iff (rst)
    of_ld_n |=> $stable(of_q));
  // R6
  inh_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !inh_n |-> (freq_sum == cf_q));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] freq_sum,
  input  logic          acc_en_n,
  input  logic          init_n,
  output logic [FW-1:0] acc_q
);
  logic [FW-1:0] feedback;

  assign feedback = init_n ? acc_q : '0;

  always_ff @(posedge clk) begin
    if (rst)           acc_q <= '0;
    else if (!acc_en_n) acc_q <= feedback + freq_sum;
  end

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    acc_en_n |=> $stable(acc_q));
  // R8
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!acc_en_n && init_n) |=> (acc_q == $past(acc_q) + $past(freq_sum)));
  // R7
  acc_init_chk: assert property (@(posedge clk) disable iff (rst)
    (!acc_en_n && !init_n) |=> (acc_q == $past(freq_sum)));
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int unsigned FW = NCO_FW,
  parameter int unsigned BW = NCO_BW,
  parameter int unsigned PW = NCO_PW,
  parameter int unsigned AW = NCO_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_n,
  input  logic          cs_n,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] cdata,
  input  logic          cf_en_n,
  input  logic          of_en_n,
  input  logic          acc_en_n,
  input  logic          inh_of_n,
  input  logic          init_acc_n,
  output logic [PW-1:0] phase_out
);
  logic [FW-1:0]       cf_stage, of_stage, freq_sum, acc_q;
  logic [NCO_NCTL-1:0] pins_n, ctl_n;

  assign pins_n[CTL_CF]   = cf_en_n;
  assign pins_n[CTL_OF]   = of_en_n;
  assign pins_n[CTL_ACC]  = acc_en_n;
  assign pins_n[CTL_INH]  = inh_of_n;
  assign pins_n[CTL_INIT] = init_acc_n;

  nco_stage_regs #(.FW(FW), .BW(BW), .AW(AW)) u_stage (
    .wr_n(wr_n), .cs_n(cs_n), .addr(addr), .cdata(cdata),
    .cf_stage(cf_stage), .of_stage(of_stage)
  );

  nco_ctl_pipe #(.N(NCO_NCTL)) u_pipe (
    .clk(clk), .rst(rst), .pins_n(pins_n), .ctl_q_n(ctl_n)
  );

  nco_freq_path #(.FW(FW)) u_freq (
    .clk(clk), .rst(rst), .cf_stage(cf_stage), .of_stage(of_stage),
    .cf_ld_n(ctl_n[CTL_CF]), .of_ld_n(ctl_n[CTL_OF]),
    .inh_n(ctl_n[CTL_INH]), .freq_sum(freq_sum)
  );

  nco_phase_acc #(.FW(FW)) u_acc (
    .clk(clk), .rst(rst), .freq_sum(freq_sum),
    .acc_en_n(ctl_n[CTL_ACC]), .init_n(ctl_n[CTL_INIT]), .acc_q(acc_q)
  );

  assign phase_out = acc_q[FW-1 -: PW];

  // R4
  pipe_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en_n && ctl_n[CTL_ACC]) |=> $stable(acc_q));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && ctl_n == '1));
endmodule

// File: tb/test_nco_phase_core.sv
`timescale 1ns/1ps
module test_nco_phase_core;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_n = 1'b1, cs_n = 1'b1;
  logic [2:0] addr = '0;
  logic [15:0] cdata = '0;
  logic cf_en_n = 1'b1, of_en_n = 1'b1, acc_en_n = 1'b1;
  logic inh_of_n = 1'b1, init_acc_n = 1'b1;
  logic [15:0] phase_out;

  int n_vec = 0, n_bad = 0;
  logic [31:0] exp_acc = '0, cf_m = '0, of_m = '0;
  bit inh_m = 1'b0;

  always #2.5 clk = ~clk;

  nco_phase_core i_nco_phase_core (
    .clk(clk), .rst(rst), .wr_n(wr_n), .cs_n(cs_n), .addr(addr),
    .cdata(cdata), .cf_en_n(cf_en_n), .of_en_n(of_en_n),
    .acc_en_n(acc_en_n), .inh_of_n(inh_of_n), .init_acc_n(init_acc_n),
    .phase_out(phase_out)
  );

  task automatic check(input string req, input logic [15:0] exp);
    n_vec++;
    if (phase_out !== exp) begin
      n_bad++;
      $display("FAIL %s phase_out=%h expected=%h", req, phase_out, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic sel_n);
    cs_n = sel_n; addr = a; cdata = d;
    #0.5 wr_n = 1'b0;
    #0.5 wr_n = 1'b1;
    #0.5 cs_n = 1'b1;
  endtask

  task automatic stage_word(input int w, input logic [31:0] v);
    wr(3'(2*w), v[15:0], 1'b0);
    wr(3'(2*w+1), v[31:16], 1'b0);
  endtask

  // pulse enables low for one cycle; registers load on the second edge
  task automatic pulse(input bit do_cf, input bit do_of);
    @(negedge clk);
    cf_en_n = ~do_cf; of_en_n = ~do_of;
    @(posedge clk); @(negedge clk);
    cf_en_n = 1'b1; of_en_n = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [31:0] sum_m();
    return cf_m + (inh_m ? 32'd0 : of_m);
  endfunction

  // acc_en_n low across k edges then high: exactly k accumulations (R4)
  task automatic run(input int k);
    @(negedge clk); acc_en_n = 1'b0;
    for (int i = 0; i < k; i++) @(posedge clk);
    @(negedge clk); acc_en_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    exp_acc = exp_acc + 32'(k) * sum_m();
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    stage_word(0, 32'h0); stage_word(1, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1 reset", 16'h0000);

    // basic accumulation, output top half (R8, R9)
    stage_word(0, 32'h0001_0000); cf_m = 32'h0001_0000;
    pulse(1, 1);
    run(3);
    check("R8 R9 basic", exp_acc[31:16]);

    // one-cycle pin pipeline (R4)
    @(negedge clk); acc_en_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R4 no action on first edge", exp_acc[31:16]);
    @(posedge clk); @(negedge clk);
    check("R4 action on second edge", 16'(exp_acc[31:16] + 16'd1));
    acc_en_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    exp_acc = exp_acc + 32'd2 * sum_m();
    check("R4 stop after one more edge", exp_acc[31:16]);

    // cs_n high: strobe ignored (R2)
    wr(3'd1, 16'h7777, 1'b1); wr(3'd0, 16'h5555, 1'b1);
    pulse(1, 0);
    run(2);
    check("R2 write without select ignored", exp_acc[31:16]);

    // addresses 4..7 ignored (R3)
    for (int a = 4; a < 8; a++) wr(3'(a), 16'hDEAD, 1'b0);
    pulse(1, 1);
    run(2);
    check("R3 high addresses ignored", exp_acc[31:16]);

    // half independence: only high half of center (R3)
    wr(3'd1, 16'h0003, 1'b0); cf_m = 32'h0003_0000;
    pulse(1, 0);
    run(2);
    check("R3 half write keeps other half", exp_acc[31:16]);

    // staged but not enabled (R5)
    stage_word(0, 32'h0100_0000);
    run(2);
    check("R5 no load without enable", exp_acc[31:16]);
    cf_m = 32'h0100_0000;
    pulse(1, 0);
    run(1);
    check("R5 load with enable", exp_acc[31:16]);

    // inhibit (R6)
    stage_word(1, 32'h0020_0000); of_m = 32'h0020_0000;
    @(negedge clk); inh_of_n = 1'b0; inh_m = 1'b1;
    pulse(0, 1);
    run(3);
    check("R6 offset removed", exp_acc[31:16]);
    @(negedge clk); inh_of_n = 1'b1; inh_m = 1'b0;
    run(3);
    check("R6 offset kept and restored", exp_acc[31:16]);

    // initialize (R7)
    @(negedge clk); init_acc_n = 1'b0;
    repeat (3) @(posedge clk); @(negedge clk);
    check("R7 no clear when disabled", exp_acc[31:16]);
    run(1);
    exp_acc = sum_m();
    check("R7 load sum only", exp_acc[31:16]);
    @(negedge clk); init_acc_n = 1'b1;
    @(posedge clk); @(negedge clk);

    // wraparound (R8)
    stage_word(0, 32'hF000_0000); stage_word(1, 32'h2000_0000);
    cf_m = 32'hF000_0000; of_m = 32'h2000_0000;
    pulse(1, 1);
    run(5);
    check("R8 wrap modulo 2^32", exp_acc[31:16]);

    // sweep of frequency words (R8, R9)
    for (int i = 0; i < 24; i++) begin
      logic [31:0] c, o;
      c = 32'(i) * 32'h1357_9BDF ^ 32'hA5A5_0000;
      o = 32'h8000_0000 >> (i % 32);
      stage_word(0, c); stage_word(1, o);
      cf_m = c; of_m = o;
      pulse(1, 1);
      run(1 + (i % 7));
      check("R8 R9 sweep", exp_acc[31:16]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule